// File: doc/BRIEF.md
# Receive Descriptor Write-Back Coalescer

This block sits on the completion side of a receive DMA engine. Completed receive descriptors arrive one at a time, in ring order. The block decides when to ask for their write-back to the host descriptor ring. Each request names a start index and a count. Completions that arrive while a request is stalled are held until they can be written back.

Two modes exist. Coming out of reset the block is in single mode, where every completion produces its own one-descriptor request. A mode-clear admin command switches it to batched mode. In batched mode, requests cover aligned groups of four descriptors (one cacheline). The exception is an interrupt, which flushes whatever was pending at that moment, even a partial group. The switch is one way: only a reset brings single mode back. The current mode is reported on a status output.

The ring depth is a parameter and must be a multiple of 32. The group size must be a power of two of at least two.

Top module: `rxwb_coalescer`

## Requirements
- R1: After reset, single_mode_o is 1 and wb_valid_o is 0.
- R2: In single mode, every completion produces its own request, with wb_count_o = 1 and wb_start_o equal to that descriptor's index, in completion order.
- R3: In batched mode, no request is made until the group of four containing the oldest pending index is complete. Groups are aligned to indices that are multiples of four. The request then covers from the oldest pending index to the group's end, which is a full group of 4 when that index is aligned.
- R4: In batched mode, a pulse on irq_i flushes every descriptor pending in that cycle, even when its group is incomplete. Each request still stops at a group boundary. A pulse with nothing pending makes no request.
- R5: After a partial flush, write-back resumes at the next unflushed index. The following request covers only the rest of that group, so no descriptor is written back twice.
- R6: A command with cmd_opcode_i = 0x0110 and cmd_magic_i = 0x02 clears single mode. A command with any other magic byte or opcode leaves single_mode_o at 1.
- R7: Once single_mode_o is 0 it stays 0 until reset, even when further clear commands arrive.
- R8: If the clear command arrives while descriptors are pending or a request is outstanding, those descriptors are first written back as single requests (count 1). single_mode_o falls only after that drain is done.
- R9: A request is held stable while wb_valid_o is high and wb_ready_i is low. Completions arriving during a stall are kept, up to RING_DEPTH of them, and are written back later in order. No request crosses a group boundary or the ring end.
- R10: wb_status_o carries the status of the last descriptor covered by the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_idx_i | input | IDX_W | Ring index of the completed descriptor (must be the next in ring order) |
| cmpl_status_i | input | STAT_W | Status of the completed descriptor |
| irq_i | input | 1 | Interrupt-fire pulse, forces a flush in batched mode |
| cmd_valid_i | input | 1 | Admin command strobe |
| cmd_opcode_i | input | 16 | Admin command opcode |
| cmd_magic_i | input | 8 | First parameter byte of the command |
| wb_valid_o | output | 1 | Write-back request valid |
| wb_ready_i | input | 1 | Write-back request accepted |
| wb_start_o | output | IDX_W | First ring index to write back |
| wb_count_o | output | GCNT_W | Number of descriptors to write back |
| wb_status_o | output | STAT_W | Status of the last descriptor in the request |
| single_mode_o | output | 1 | Mode status: 1 = single mode, 0 = batched mode |

## Verification
Single-mode completions come in spaced one by one; a block that batches them would merge indices. Batched mode is tried three ways: with a group started mid-way (offset 2), with aligned groups, and with a group filled one index at a time. These show that a group is held until complete, and that its count is measured from the oldest pending index. Interrupt pulses land on two, three and zero pending descriptors. The completions that follow each one show where write-back resumes and confirm that nothing is sent twice. A sixteen-deep burst under a held-low ready crosses the ring end; wrong magic and wrong opcode commands sit beside a clear sent during a stall, which tells a gated, draining, one-way switch from a plain flag.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam logic [15:0] CMD_CLR_OPCODE = 16'h0110;
  localparam logic [7:0]  CMD_CLR_MAGIC  = 8'h02;
endpackage

// File: rtl/rxwb_stat_mem.sv
module rxwb_stat_mem #(
  parameter int RING_DEPTH = 32,
  parameter int STAT_W     = 8,
  localparam int IDX_W     = $clog2(RING_DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [STAT_W-1:0] wr_stat_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [STAT_W-1:0] rd_stat_o
);
  logic [STAT_W-1:0] mem_q [RING_DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_stat_i;
  end

  assign rd_stat_o = mem_q[rd_idx_i];
endmodule

// File: rtl/rxwb_mode_ctl.sv
module rxwb_mode_ctl
  import rxwb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [15:0] cmd_opcode_i,
  input  logic [7:0]  cmd_magic_i,
  input  logic        idle_i,
  output logic        single_mode_o
);
  logic clr_pend_q;
  logic cmd_hit;

  assign cmd_hit = cmd_valid_i && (cmd_opcode_i == CMD_CLR_OPCODE)
                   && (cmd_magic_i == CMD_CLR_MAGIC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_mode_o <= 1'b1;
      clr_pend_q    <= 1'b0;
    end else begin
      if (cmd_hit && single_mode_o) clr_pend_q <= 1'b1;
      // switch only once the drain in single mode is complete
      if (clr_pend_q && idle_i) begin
        single_mode_o <= 1'b0;
        clr_pend_q    <= 1'b0;
      end
    end
  end

  AST_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_mode_o |=> !single_mode_o); // R7
  AST_DRAIN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(single_mode_o) |-> $past(idle_i)); // R8
endmodule

// File: rtl/rxwb_sched.sv
module rxwb_sched #(
  parameter int RING_DEPTH = 32,
  parameter int GROUP      = 4,
  parameter int STAT_W     = 8,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int CNT_W     = $clog2(RING_DEPTH + 1),
  localparam int OFF_W     = $clog2(GROUP),
  localparam int GCNT_W    = $clog2(GROUP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              single_mode_i,
  input  logic              cmpl_valid_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic              irq_i,
  input  logic              wb_ready_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [STAT_W-1:0] rd_stat_i,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_start_o,
  output logic [GCNT_W-1:0] wb_count_o,
  output logic [STAT_W-1:0] wb_status_o,
  output logic              idle_o
);
  logic [IDX_W-1:0]  head_q, tail_q, head_nxt, tail_nxt;
  logic [CNT_W-1:0]  cnt_q, force_q, issued;
  logic [GCNT_W-1:0] room, n;
  logic [IDX_W:0]    head_sum, tail_sum;
  logic              go;

  assign room = GCNT_W'(GROUP) - GCNT_W'(head_q[OFF_W-1:0]);

  always_comb begin
    go = 1'b0;
    n  = '0;
    if (!wb_valid_o) begin
      if (single_mode_i) begin
        if (cnt_q != '0) begin go = 1'b1; n = GCNT_W'(1); end
      end else if (cnt_q >= CNT_W'(room)) begin
        go = 1'b1; n = room;
      end else if (force_q != '0) begin
        go = 1'b1; n = GCNT_W'(force_q); // force_q < room here
      end
    end
  end

  assign issued   = go ? CNT_W'(n) : '0;
  assign head_sum = {1'b0, head_q} + (IDX_W+1)'(n);
  assign head_nxt = (head_sum == (IDX_W+1)'(RING_DEPTH)) ? '0 : head_sum[IDX_W-1:0];
  assign tail_sum = {1'b0, tail_q} + (IDX_W+1)'(1);
  assign tail_nxt = (tail_sum == (IDX_W+1)'(RING_DEPTH)) ? '0 : tail_sum[IDX_W-1:0];
  assign rd_idx_o = head_q + IDX_W'(n) - IDX_W'(1);
  assign idle_o   = (cnt_q == '0) && !wb_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q      <= '0;
      tail_q      <= '0;
      cnt_q       <= '0;
      force_q     <= '0;
      wb_valid_o  <= 1'b0;
      wb_start_o  <= '0;
      wb_count_o  <= '0;
      wb_status_o <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(cmpl_valid_i) - issued;
      if (cmpl_valid_i) tail_q <= tail_nxt;
      if (single_mode_i)             force_q <= '0;
      else if (irq_i)                force_q <= cnt_q - issued;
      else if (force_q > issued)     force_q <= force_q - issued;
      else                           force_q <= '0;
      if (go) begin
        head_q      <= head_nxt;
        wb_valid_o  <= 1'b1;
        wb_start_o  <= head_q;
        wb_count_o  <= n;
        wb_status_o <= rd_stat_i;
      end else if (wb_valid_o && wb_ready_i) begin
        wb_valid_o  <= 1'b0;
      end
    end
  end

  AST_SINGLE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && single_mode_i) |-> (wb_count_o == GCNT_W'(1))); // R2
  AST_NO_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> ((GCNT_W+1)'(wb_start_o[OFF_W-1:0]) + (GCNT_W+1)'(wb_count_o)
                    <= (GCNT_W+1)'(GROUP))); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=>
      (wb_valid_o && $stable(wb_start_o) && $stable(wb_count_o))); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i |-> (cnt_q < CNT_W'(RING_DEPTH))); // R9
  AST_IN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i |-> (cmpl_idx_i == tail_q)); // R2
  AST_FORCE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_q <= cnt_q); // R4
endmodule

// File: rtl/rxwb_coalescer.sv
module rxwb_coalescer #(
  parameter int RING_DEPTH = 32,
  parameter int GROUP      = 4,
  parameter int STAT_W     = 8,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int GCNT_W    = $clog2(GROUP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmpl_valid_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic [STAT_W-1:0] cmpl_status_i,
  input  logic              irq_i,
  input  logic              cmd_valid_i,
  input  logic [15:0]       cmd_opcode_i,
  input  logic [7:0]        cmd_magic_i,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [IDX_W-1:0]  wb_start_o,
  output logic [GCNT_W-1:0] wb_count_o,
  output logic [STAT_W-1:0] wb_status_o,
  output logic              single_mode_o
);
  logic [IDX_W-1:0]  rd_idx;
  logic [STAT_W-1:0] rd_stat;
  logic              idle;

  rxwb_stat_mem #(.RING_DEPTH(RING_DEPTH), .STAT_W(STAT_W)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (cmpl_valid_i),
    .wr_idx_i  (cmpl_idx_i),
    .wr_stat_i (cmpl_status_i),
    .rd_idx_i  (rd_idx),
    .rd_stat_o (rd_stat)
  );

  rxwb_sched #(.RING_DEPTH(RING_DEPTH), .GROUP(GROUP), .STAT_W(STAT_W)) u_sched (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .single_mode_i (single_mode_o),
    .cmpl_valid_i  (cmpl_valid_i),
    .cmpl_idx_i    (cmpl_idx_i),
    .irq_i         (irq_i),
    .wb_ready_i    (wb_ready_i),
    .rd_idx_o      (rd_idx),
    .rd_stat_i     (rd_stat),
    .wb_valid_o    (wb_valid_o),
    .wb_start_o    (wb_start_o),
    .wb_count_o    (wb_count_o),
    .wb_status_o   (wb_status_o),
    .idle_o        (idle)
  );

  rxwb_mode_ctl u_mode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_opcode_i  (cmd_opcode_i),
    .cmd_magic_i   (cmd_magic_i),
    .idle_i        (idle),
    .single_mode_o (single_mode_o)
  );
endmodule

// File: tb/rxwb_coalescer_tb.sv
`timescale 1ns/1ps
module rxwb_coalescer_tb;
  localparam int RING = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmpl_valid = 1'b0;
  logic [4:0] cmpl_idx = '0;
  logic [7:0] cmpl_status = '0;
  logic       irq = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [15:0] cmd_opcode = '0;
  logic [7:0] cmd_magic = '0;
  logic       wb_valid, wb_ready = 1'b1, single_mode;
  logic [4:0] wb_start;
  logic [2:0] wb_count;
  logic [7:0] wb_status;

  int checks = 0, failures = 0, log_n = 0, seen = 0;
  int log_start [64];
  int log_count [64];
  int log_stat  [64];
  bit done = 0;

  always #4 clk = ~clk;

  rxwb_coalescer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmpl_valid_i(cmpl_valid), .cmpl_idx_i(cmpl_idx),
    .cmpl_status_i(cmpl_status), .irq_i(irq), .cmd_valid_i(cmd_valid),
    .cmd_opcode_i(cmd_opcode), .cmd_magic_i(cmd_magic), .wb_valid_o(wb_valid),
    .wb_ready_i(wb_ready), .wb_start_o(wb_start), .wb_count_o(wb_count),
    .wb_status_o(wb_status), .single_mode_o(single_mode)
  );

  always @(posedge clk) begin
    if (rst_n && wb_valid && wb_ready && log_n < 64) begin
      log_start[log_n] = int'(wb_start);
      log_count[log_n] = int'(wb_count);
      log_stat[log_n]  = int'(wb_status);
      log_n++;
    end
  end

  function automatic int stat_of(int idx);
    return (idx ^ 8'hA5) & 8'hFF;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(int idx);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_idx = 5'(idx); cmpl_status = 8'(stat_of(idx));
    @(negedge clk);
    cmpl_valid = 1'b0;
  endtask

  task automatic fire_irq();
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
  endtask

  task automatic send_cmd(int op, int magic);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = 16'(op); cmd_magic = 8'(magic);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // compare next logged request with expectation, status tied to last index
  task automatic expect_req(int start, int count, string req);
    if (seen >= log_n) begin
      check(0, {req, " missing request start"}, -1, start);
      return;
    end
    check(log_start[seen] == start, {req, " start"}, log_start[seen], start);
    check(log_count[seen] == count, {req, " count"}, log_count[seen], count);
    check(log_stat[seen] == stat_of(start + count - 1), "R10 status",
          log_stat[seen], stat_of(start + count - 1));
    seen++;
  endtask

  task automatic expect_none(string req);
    check(log_n == seen, {req, " no request"}, log_n, seen);
  endtask

  task automatic t_reset();
    check(single_mode == 1'b1, "R1 single_mode", int'(single_mode), 1);
    check(wb_valid == 1'b0, "R1 wb_valid", int'(wb_valid), 0);
  endtask

  task automatic t_single();
    for (int i = 0; i < 3; i++) push(i);
    idle(8);
    expect_req(0, 1, "R2");
    expect_req(1, 1, "R2");
    expect_req(2, 1, "R2");
  endtask

  task automatic t_bad_cmd();
    send_cmd(16'h0110, 8'h03);
    send_cmd(16'h0111, 8'h02);
    idle(4);
    check(single_mode == 1'b1, "R6 wrong magic/opcode", int'(single_mode), 1);
    push(3);
    idle(6);
    expect_req(3, 1, "R6 still single");
  endtask

  task automatic t_drain();
    wb_ready = 1'b0;
    push(4); push(5);
    send_cmd(16'h0110, 8'h02);
    idle(4);
    check(single_mode == 1'b1, "R8 mode held while pending", int'(single_mode), 1);
    wb_ready = 1'b1;
    idle(10);
    expect_req(4, 1, "R8");
    expect_req(5, 1, "R8");
    check(single_mode == 1'b0, "R6 mode cleared", int'(single_mode), 0);
  endtask

  task automatic t_batched();
    push(6); idle(6);
    expect_none("R3 partial group held");
    push(7); idle(6);
    expect_req(6, 2, "R3");
    for (int i = 8; i < 12; i++) push(i);
    idle(6);
    expect_req(8, 4, "R3");
  endtask

  task automatic t_irq();
    push(12); push(13); push(14); idle(6);
    expect_none("R3 three of four held");
    fire_irq(); idle(6);
    expect_req(12, 3, "R4");
    push(15); idle(6);
    expect_req(15, 1, "R5");
    push(16); push(17); fire_irq(); idle(6);
    expect_req(16, 2, "R4");
    push(18); idle(6);
    expect_none("R5 resumed group held");
    push(19); idle(6);
    expect_req(18, 2, "R5");
  endtask

  task automatic t_stall();
    wb_ready = 1'b0;
    for (int i = 20; i < 36; i++) push(i % RING);
    idle(2);
    check(wb_valid == 1'b1, "R9 request pending", int'(wb_valid), 1);
    check(wb_start == 5'd20, "R9 start held", int'(wb_start), 20);
    idle(3);
    check(wb_start == 5'd20 && wb_count == 3'd4, "R9 stable", int'(wb_start), 20);
    wb_ready = 1'b1;
    idle(16);
    expect_req(20, 4, "R9");
    expect_req(24, 4, "R9");
    expect_req(28, 4, "R9");
    expect_req(0, 4, "R9 ring wrap");
  endtask

  task automatic t_one_way();
    send_cmd(16'h0110, 8'h02);
    idle(4);
    check(single_mode == 1'b0, "R7 stays batched", int'(single_mode), 0);
    push(4); idle(6);
    expect_none("R7 batched holds single completion");
    fire_irq(); idle(6);
    expect_req(4, 1, "R4");
    fire_irq(); idle(6);
    expect_none("R4 empty interrupt");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset();
    t_single();
    t_bad_cmd();
    t_drain();
    t_batched();
    t_irq();
    t_stall();
    t_one_way();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule